// File: doc/BRIEF.md
# Multichannel Decimating FIR Filter

This block low-pass filters and decimates a stream of samples from several channels that share one input. A single multiply-accumulate datapath is shared over time by all channels. Samples arrive one per valid strobe, in rising channel order, so a group of samples holding one sample per channel forms a frame. The filter keeps a circular sample history for each channel. After every `DECIM` frames it produces one output per channel. It computes only these kept outputs and never the discarded ones.

The impulse response is symmetric, so only half of the coefficients are stored. The two samples that share a coefficient are added before the multiply, which halves the number of multiply cycles per output. Passband gain comes only from how the coefficients are normalised. The output is a fixed slice of the 48-bit accumulator, rounded and saturated.

The host controls the filter in three steps. It stops the filter, writes coefficients through a small write port, and starts the filter again. The switch-over point is therefore exact, and every start begins from an empty history.

Top module: `mc_decim_fir`

## Requirements
- R1: `inData` is a 20-bit signed sample and `cfgData` is an 18-bit signed coefficient. After a start, the first accepted sample belongs to channel 0. Each following accepted sample belongs to the next channel, wrapping after channel `NUM_CH-1`. Frame f (numbered from 0 after the start) holds one sample for every channel.
- R2: Coefficient address a (0 to `TAPS/2-1`) holds the tap weight h[a]. The same value is used for the mirrored tap h[`TAPS-1-a`]. For channel c at frame f, the output is y = round(sum over k=0..`TAPS-1` of h[k]·x_c[f-k] / 2^17), computed exactly in a 48-bit accumulator. Coefficients that sum to 2^17 over all taps therefore give unity gain.
- R3: An output is produced only for frames with f mod `DECIM` = `DECIM-1`. Each such frame gives exactly `NUM_CH` outputs, and the first comes after frame `DECIM-1`.
- R4: A one-cycle `startReq` pulse resets the channel position, the decimation phase and the history. Any sample taken before that start counts as zero. A start is only issued while no output computation is in progress.
- R5: The output rounds half up. The block adds 2^16 to the accumulator and then shifts it right arithmetically by 17 bits. So +1.5 gives 2 and -1.5 gives -1.
- R6: The output saturates to the range -524288 to 524287 instead of wrapping.
- R7: Each output is marked by a single-cycle `outValid`, with `outChan` giving its channel. Within a frame, outputs leave in ascending channel order.
- R8: A coefficient write (`cfgWrEn` high with `cfgAddr` and `cfgData`) takes effect only while the filter is stopped. A write issued while the filter runs is ignored.
- R9: A `stopReq` pulse halts the filter. While the filter is stopped, input samples are ignored and no output is produced.
- R10: A channel's output appears no more than `TAPS/2+6` cycles after the sample that completes its window. Accepted input samples must be spaced at least that many cycles apart.
- R11: After reset the filter is stopped, every coefficient is zero and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse; clears history, phase and channel position |
| stopReq | input | 1 | Stop pulse |
| cfgWrEn | input | 1 | Coefficient write strobe |
| cfgAddr | input | $clog2(TAPS/2) | Coefficient address |
| cfgData | input | COEF_W | Signed coefficient value |
| inValid | input | 1 | Input sample strobe |
| inData | input | IN_W | Signed input sample |
| outValid | output | 1 | Output sample strobe |
| outChan | output | $clog2(NUM_CH) | Channel of the output sample |
| outData | output | OUT_W | Rounded, saturated output sample |

## Verification
Each fault inside the block shows at the ports in its own way.

- A wrong history slot or a wrong fill count changes the output value on the very next decimated frame.
- A wrong decimation phase or channel position shows up as a missing or extra output, or as a wrong `outChan`, within one decimation period.
- A coefficient write that slips through while the filter runs changes the next output value.
- A start that fails to clear the history shows up as a wrong value in the first output after the restart.

The bench computes every output from its own direct-form model and compares it with the output sample by sample.

// File: rtl/mc_decim_pkg.sv
package mc_decim_pkg;
  // Per-tap strobes travelling from the sequencer into the arithmetic pipeline
  typedef struct packed {
    logic issue;  // a tap pair is read this cycle
    logic first;  // first pair of an output: accumulator restarts
    logic last;   // last pair of an output: result is emitted
  } tapStrobe_t;
endpackage

// File: rtl/mc_decim_ctrl.sv
module mc_decim_ctrl
  import mc_decim_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TAPS   = 64,
  parameter int DECIM  = 8
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    startReq,
  input  logic                                    stopReq,
  input  logic                                    inValid,
  input  logic                                    cfgWrEn,
  output logic                                    running,
  output logic                                    busy,
  output logic                                    coefWe,
  output logic                                    memWe,
  output logic [$clog2(NUM_CH*TAPS)-1:0]          memWrAddr,
  output logic [$clog2(NUM_CH*TAPS)-1:0]          memRdAddrA,
  output logic [$clog2(NUM_CH*TAPS)-1:0]          memRdAddrB,
  output logic [((TAPS/2)>1 ? $clog2(TAPS/2) : 1)-1:0] coefRdAddr,
  output logic                                    maskA,
  output logic                                    maskB,
  output tapStrobe_t                              tapCtl,
  output logic [(NUM_CH>1 ? $clog2(NUM_CH) : 1)-1:0] tapChan
);
  localparam int HALF   = TAPS / 2;
  localparam int CH_W   = NUM_CH > 1 ? $clog2(NUM_CH) : 1;
  localparam int SLOT_W = $clog2(TAPS);
  localparam int CA_W   = HALF > 1 ? $clog2(HALF) : 1;
  localparam int MEM_AW = $clog2(NUM_CH * TAPS);
  localparam int PH_W   = DECIM > 1 ? $clog2(DECIM) : 1;
  localparam int FILL_W = $clog2(TAPS + 1);

  logic [CH_W-1:0]   chanCnt, curChan;
  logic [SLOT_W-1:0] wrSlot, baseSlot, slotA, slotB;
  logic [PH_W-1:0]   phase;
  logic [FILL_W-1:0] filled, baseFilled, fillNext;
  logic [CA_W-1:0]   tapIdx;
  logic              take, frameEnd, lastTap;

  assign take     = inValid && running;
  assign frameEnd = (chanCnt == CH_W'(NUM_CH - 1));
  assign fillNext = (filled == FILL_W'(TAPS)) ? filled : filled + 1'b1;
  assign lastTap  = (tapIdx == CA_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running    <= 1'b0;
      busy       <= 1'b0;
      chanCnt    <= '0;
      curChan    <= '0;
      wrSlot     <= '0;
      baseSlot   <= '0;
      phase      <= '0;
      filled     <= '0;
      baseFilled <= '0;
      tapIdx     <= '0;
    end else if (startReq) begin
      running <= 1'b1;
      busy    <= 1'b0;
      chanCnt <= '0;
      wrSlot  <= '0;
      phase   <= '0;
      filled  <= '0;
      tapIdx  <= '0;
    end else begin
      if (stopReq) running <= 1'b0;
      if (busy) begin
        tapIdx <= tapIdx + 1'b1;
        if (lastTap) busy <= 1'b0;
      end
      if (take) begin
        chanCnt <= frameEnd ? '0 : chanCnt + 1'b1;
        if (frameEnd) begin
          wrSlot <= (wrSlot == SLOT_W'(TAPS - 1)) ? '0 : wrSlot + 1'b1;
          phase  <= (phase == PH_W'(DECIM - 1)) ? '0 : phase + 1'b1;
          filled <= fillNext;
        end
        if (phase == PH_W'(DECIM - 1)) begin
          busy       <= 1'b1;
          tapIdx     <= '0;
          curChan    <= chanCnt;
          baseSlot   <= wrSlot;
          baseFilled <= fillNext;
        end
      end
    end
  end

  // Newer tap k and its mirror TAPS-1-k, located behind the newest slot
  always_comb begin
    int k, m, da, db;
    k  = int'(tapIdx);
    m  = TAPS - 1 - k;
    da = int'(baseSlot) - k;
    if (da < 0) da = da + TAPS;
    db = int'(baseSlot) - m;
    if (db < 0) db = db + TAPS;
    slotA = SLOT_W'(da);
    slotB = SLOT_W'(db);
    maskA = k < int'(baseFilled);
    maskB = m < int'(baseFilled);
    memRdAddrA = MEM_AW'(int'(curChan) * TAPS + int'(slotA));
    memRdAddrB = MEM_AW'(int'(curChan) * TAPS + int'(slotB));
  end

  assign memWrAddr    = MEM_AW'(int'(chanCnt) * TAPS + int'(wrSlot));
  assign memWe        = take;
  assign coefWe       = cfgWrEn && !running;
  assign coefRdAddr   = tapIdx;
  assign tapCtl.issue = busy;
  assign tapCtl.first = busy && (tapIdx == '0);
  assign tapCtl.last  = busy && lastTap;
  assign tapChan      = curChan;
endmodule

// File: rtl/mc_decim_path.sv
module mc_decim_path
  import mc_decim_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TAPS   = 64,
  parameter int IN_W   = 20,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 20,
  parameter int FRAC   = COEF_W - 1
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    memWe,
  input  logic [$clog2(NUM_CH*TAPS)-1:0]          memWrAddr,
  input  logic signed [IN_W-1:0]                  inData,
  input  logic                                    coefWe,
  input  logic [((TAPS/2)>1 ? $clog2(TAPS/2) : 1)-1:0] coefWrAddr,
  input  logic signed [COEF_W-1:0]                coefData,
  input  logic [$clog2(NUM_CH*TAPS)-1:0]          memRdAddrA,
  input  logic [$clog2(NUM_CH*TAPS)-1:0]          memRdAddrB,
  input  logic [((TAPS/2)>1 ? $clog2(TAPS/2) : 1)-1:0] coefRdAddr,
  input  logic                                    maskA,
  input  logic                                    maskB,
  input  tapStrobe_t                              tapCtl,
  input  logic [(NUM_CH>1 ? $clog2(NUM_CH) : 1)-1:0] tapChan,
  output logic                                    outValid,
  output logic [(NUM_CH>1 ? $clog2(NUM_CH) : 1)-1:0] outChan,
  output logic signed [OUT_W-1:0]                 outData
);
  localparam int HALF   = TAPS / 2;
  localparam int DEPTH  = NUM_CH * TAPS;
  localparam int CH_W   = NUM_CH > 1 ? $clog2(NUM_CH) : 1;
  localparam int PRE_W  = IN_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) << (OUT_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) << (OUT_W - 1));

  logic signed [IN_W-1:0]   histMem [DEPTH];
  logic signed [COEF_W-1:0] coefMem [HALF];

  // stage 1: memory reads
  logic signed [IN_W-1:0]   rdA, rdB;
  logic signed [COEF_W-1:0] rdC;
  logic                     s1MaskA, s1MaskB;
  tapStrobe_t               s1Ctl, s2Ctl, s3Ctl;
  logic [CH_W-1:0]          s1Chan, s2Chan, s3Chan;
  // stage 2: folded product, stage 3: accumulator
  logic signed [PRE_W-1:0]  preSum;
  logic signed [PROD_W-1:0] prodReg;
  logic signed [ACC_W-1:0]  accReg, rounded, shifted;

  always_ff @(posedge clk) begin
    if (memWe) histMem[memWrAddr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HALF; i++) coefMem[i] <= '0;
    end else if (coefWe) begin
      coefMem[coefWrAddr] <= coefData;
    end
  end

  always_ff @(posedge clk) begin
    rdA <= histMem[memRdAddrA];
    rdB <= histMem[memRdAddrB];
    rdC <= coefMem[coefRdAddr];
  end

  always_comb begin
    preSum = (s1MaskA ? PRE_W'(rdA) : '0) + (s1MaskB ? PRE_W'(rdB) : '0);
  end

  always_ff @(posedge clk) begin
    prodReg <= PROD_W'(preSum) * PROD_W'(rdC);
    if (s2Ctl.issue) accReg <= s2Ctl.first ? ACC_W'(prodReg) : accReg + ACC_W'(prodReg);
  end

  always_comb begin
    rounded = accReg + RND;
    shifted = rounded >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Ctl    <= '0;
      s2Ctl    <= '0;
      s3Ctl    <= '0;
      s1MaskA  <= 1'b0;
      s1MaskB  <= 1'b0;
      s1Chan   <= '0;
      s2Chan   <= '0;
      s3Chan   <= '0;
      outValid <= 1'b0;
      outChan  <= '0;
      outData  <= '0;
    end else begin
      s1Ctl    <= tapCtl;
      s1MaskA  <= maskA;
      s1MaskB  <= maskB;
      s1Chan   <= tapChan;
      s2Ctl    <= s1Ctl;
      s2Chan   <= s1Chan;
      s3Ctl    <= s2Ctl;
      s3Chan   <= s2Chan;
      outValid <= s3Ctl.issue && s3Ctl.last;
      if (s3Ctl.issue && s3Ctl.last) begin
        outChan <= s3Chan;
        if (shifted > MAXV)      outData <= MAXV[OUT_W-1:0];
        else if (shifted < MINV) outData <= MINV[OUT_W-1:0];
        else                     outData <= shifted[OUT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mc_decim_fir.sv
module mc_decim_fir
  import mc_decim_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TAPS   = 64,
  parameter int DECIM  = 8,
  parameter int IN_W   = 20,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 20
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         startReq,
  input  logic                                         stopReq,
  input  logic                                         cfgWrEn,
  input  logic [((TAPS/2)>1 ? $clog2(TAPS/2) : 1)-1:0] cfgAddr,
  input  logic signed [COEF_W-1:0]                     cfgData,
  input  logic                                         inValid,
  input  logic signed [IN_W-1:0]                       inData,
  output logic                                         outValid,
  output logic [(NUM_CH>1 ? $clog2(NUM_CH) : 1)-1:0]   outChan,
  output logic signed [OUT_W-1:0]                      outData
);
  localparam int CH_W   = NUM_CH > 1 ? $clog2(NUM_CH) : 1;
  localparam int CA_W   = (TAPS / 2) > 1 ? $clog2(TAPS / 2) : 1;
  localparam int MEM_AW = $clog2(NUM_CH * TAPS);

  logic              running, busy, coefWe, memWe, maskA, maskB;
  logic [MEM_AW-1:0] memWrAddr, memRdAddrA, memRdAddrB;
  logic [CA_W-1:0]   coefRdAddr;
  logic [CH_W-1:0]   tapChan;
  tapStrobe_t        tapCtl;

  mc_decim_ctrl #(.NUM_CH(NUM_CH), .TAPS(TAPS), .DECIM(DECIM)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .inValid(inValid), .cfgWrEn(cfgWrEn), .running(running), .busy(busy),
    .coefWe(coefWe), .memWe(memWe), .memWrAddr(memWrAddr),
    .memRdAddrA(memRdAddrA), .memRdAddrB(memRdAddrB), .coefRdAddr(coefRdAddr),
    .maskA(maskA), .maskB(maskB), .tapCtl(tapCtl), .tapChan(tapChan)
  );

  mc_decim_path #(
    .NUM_CH(NUM_CH), .TAPS(TAPS), .IN_W(IN_W), .COEF_W(COEF_W),
    .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .memWe(memWe), .memWrAddr(memWrAddr),
    .inData(inData), .coefWe(coefWe), .coefWrAddr(cfgAddr), .coefData(cfgData),
    .memRdAddrA(memRdAddrA), .memRdAddrB(memRdAddrB), .coefRdAddr(coefRdAddr),
    .maskA(maskA), .maskB(maskB), .tapCtl(tapCtl), .tapChan(tapChan),
    .outValid(outValid), .outChan(outChan), .outData(outData)
  );
endmodule

// File: rtl/mc_decim_fir_chk.sv
module mc_decim_fir_chk #(
  parameter int NUM_CH = 16,
  parameter int TAPS   = 64,
  parameter int DECIM  = 8
) (
  input logic                                       clk,
  input logic                                       rstN,
  input logic                                       startReq,
  input logic                                       inValid,
  input logic                                       running,
  input logic                                       busy,
  input logic                                       outValid,
  input logic [(NUM_CH>1 ? $clog2(NUM_CH) : 1)-1:0] outChan
);
  localparam int CH_W    = NUM_CH > 1 ? $clog2(NUM_CH) : 1;
  localparam int MIN_GAP = TAPS / 2 + 6;
  localparam int PERIOD  = NUM_CH * DECIM;

  logic [15:0]     sinceIn;
  logic [31:0]     inCnt, outCnt, allowed, inMod;
  logic [CH_W-1:0] nextChan;
  logic            take;

  assign take = inValid && running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceIn  <= '1;
      inCnt    <= '0;
      outCnt   <= '0;
      nextChan <= '0;
    end else begin
      if (take) sinceIn <= '0;
      else if (sinceIn != '1) sinceIn <= sinceIn + 1'b1;
      if (startReq) begin
        inCnt    <= '0;
        outCnt   <= '0;
        nextChan <= '0;
      end else begin
        if (take) inCnt <= inCnt + 1;
        if (outValid) begin
          outCnt   <= outCnt + 1;
          nextChan <= (nextChan == CH_W'(NUM_CH - 1)) ? '0 : nextChan + 1'b1;
        end
      end
    end
  end

  // outputs earned so far: full periods plus samples of the decimated frame
  always_comb begin
    inMod   = inCnt % PERIOD;
    allowed = (inCnt / PERIOD) * NUM_CH;
    if (inMod > 32'((DECIM - 1) * NUM_CH)) allowed = allowed + inMod - 32'((DECIM - 1) * NUM_CH);
  end

  p_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    take |-> (sinceIn >= 16'(MIN_GAP - 1)));

  p_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outChan == nextChan));

  p_rate_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCnt < allowed));

  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> !busy);
endmodule

bind mc_decim_fir mc_decim_fir_chk #(.NUM_CH(NUM_CH), .TAPS(TAPS), .DECIM(DECIM)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .inValid(inValid),
  .running(running), .busy(busy), .outValid(outValid), .outChan(outChan)
);

// File: tb/mc_decim_fir_test.sv
module mc_decim_fir_test;
  localparam int CLK_PERIOD = 10;
  localparam int CH    = 4;
  localparam int TAPS  = 64;
  localparam int DECIM = 8;
  localparam int HALF  = TAPS / 2;
  localparam int GAP   = 40;
  localparam int MAXF  = 64;
  localparam int NTBL  = 7;
  // {flat coefficient, DC input level, expected steady output}
  localparam int TBL [NTBL][3] = '{
    '{2048,  1000,    1000},
    '{2048,  -524288, -524288},
    '{4096,  300000,  524287},
    '{4096,  -300000, -524288},
    '{1024,  3,       2},
    '{1024,  -3,      -1},
    '{-2048, 5000,    -5000}
  };

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0, stopReq = 1'b0;
  logic cfgWrEn = 1'b0, inValid = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic signed [17:0] cfgData = '0;
  logic signed [19:0] inData = '0;
  logic outValid;
  logic [1:0] outChan;
  logic signed [19:0] outData;

  mc_decim_fir #(.NUM_CH(CH), .TAPS(TAPS), .DECIM(DECIM)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inData(inData),
    .outValid(outValid), .outChan(outChan), .outData(outData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0, capCount = 0;
  int capData [1024];
  int capChan [1024];
  int xs [CH][MAXF];
  int coefShadow [HALF];
  int unsigned seed = 32'h1234_5678;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (outValid && capCount < 1024) begin
      capData[capCount] = int'(outData);
      capChan[capCount] = int'(outChan);
      capCount++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % 32'd1048576) - 524288;
  endfunction

  function automatic int modelY(int ch, int f);
    longint s = 0;
    longint r;
    for (int k = 0; k < TAPS; k++) begin
      if (f - k >= 0) s += longint'(coefShadow[k < HALF ? k : TAPS - 1 - k]) * longint'(xs[ch][f - k]);
    end
    r = (s + 65536) >>> 17;
    if (r > 524287) r = 524287;
    if (r < -524288) r = -524288;
    return int'(r);
  endfunction

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
  endtask

  task automatic writeCoef(input int a, input int v);
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = 5'(a); cfgData = 18'(v);
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic loadFlat(input int v);
    for (int a = 0; a < HALF; a++) begin
      writeCoef(a, v);
      coefShadow[a] = v;
    end
  endtask

  // midWrite >= 0: in that frame four coefficient writes are issued while running
  task automatic feed(input int nFrames, input bit useDc, input int dc, input int midWrite);
    for (int f = 0; f < nFrames; f++) begin
      for (int c = 0; c < CH; c++) begin
        int v;
        v = useDc ? dc : nextRand();
        xs[c][f] = v;
        @(negedge clk); inValid = 1'b1; inData = 20'(v);
        @(negedge clk); inValid = 1'b0;
        if (f == midWrite && c == 0) begin
          for (int a = 0; a < 4; a++) writeCoef(a, 60000);
          repeat (GAP - 10) @(negedge clk);
        end else begin
          repeat (GAP - 2) @(negedge clk);
        end
      end
    end
  endtask

  task automatic verifyRun(input int nFrames, input string req);
    int expCount;
    expCount = (nFrames / DECIM) * CH;
    check(capCount == expCount, "R3", {req, " output count"}, capCount, expCount);
    for (int i = 0; i < capCount && i < expCount; i++) begin
      int f, c, e;
      f = (i / CH) * DECIM + DECIM - 1;
      c = i % CH;
      e = modelY(c, f);
      check(capChan[i] == c, "R7", "channel order", capChan[i], c);
      check(capData[i] == e, req, "output value", capData[i], e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < HALF; a++) coefShadow[a] = 0;
    repeat (5) @(negedge clk);
    check(outValid == 1'b0, "R11", "outValid during reset", int'(outValid), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R11", "outValid after reset", int'(outValid), 0);

    // R11: coefficients are zero after reset, so a run yields zero outputs
    capCount = 0;
    pulseStart();
    feed(8, 1'b0, 0, -1);
    repeat (60) @(negedge clk);
    verifyRun(8, "R11");

    // R9: samples while stopped give no output
    pulseStop();
    capCount = 0;
    feed(8, 1'b0, 0, -1);
    repeat (60) @(negedge clk);
    check(capCount == 0, "R9", "outputs while stopped", capCount, 0);

    // R2 and R8: symmetric folded response, writes during a run ignored
    for (int a = 0; a < HALF; a++) begin
      coefShadow[a] = ((a * 73) % 401 - 200) * 16;
      writeCoef(a, coefShadow[a]);
    end
    capCount = 0;
    pulseStart();
    feed(40, 1'b0, 0, 20);
    repeat (60) @(negedge clk);
    verifyRun(40, "R2 R8");

    // R4: restart clears history; R1 channel position restarts at 0
    pulseStop();
    pulseStart();
    capCount = 0;
    feed(16, 1'b0, 0, -1);
    repeat (60) @(negedge clk);
    verifyRun(16, "R4 R1");

    // R10: latency from completing sample to its output
    pulseStop();
    pulseStart();
    capCount = 0;
    feed(DECIM - 1, 1'b0, 0, -1);
    begin
      int lat;
      lat = 0;
      @(negedge clk); inValid = 1'b1; inData = 20'sd12345;
      @(negedge clk); inValid = 1'b0;
      while (capCount == 0 && lat < 200) begin
        @(negedge clk);
        lat++;
      end
      check(capCount == 1 && lat + 1 <= HALF + 6, "R10", "output latency", lat + 1, HALF + 6);
      repeat (GAP) @(negedge clk);
    end

    // table of flat-coefficient DC cases: R2 gain, R5 rounding, R6 saturation
    for (int t = 0; t < NTBL; t++) begin
      string tag;
      case (t)
        0, 1, 6: tag = "R2";
        2, 3:    tag = "R6";
        default: tag = "R5";
      endcase
      pulseStop();
      loadFlat(TBL[t][0]);
      capCount = 0;
      pulseStart();
      feed(MAXF, 1'b1, TBL[t][1], -1);
      repeat (60) @(negedge clk);
      check(capCount == (MAXF / DECIM) * CH, "R3", "table output count", capCount, (MAXF / DECIM) * CH);
      for (int c = 0; c < CH; c++) begin
        int idx;
        idx = (MAXF / DECIM - 1) * CH + c;
        check(capChan[idx] == c, "R7", "table channel", capChan[idx], c);
        check(capData[idx] == TBL[t][2], tag, "steady DC output", capData[idx], TBL[t][2]);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule